// File: doc/BRIEF.md
# Flags and Branch Resolution Unit

This block keeps the four condition flags of a 32-bit core and resolves jump-class instructions against them. A compare is a subtraction whose difference is thrown away: when the flag-load strobe is high, the zero, carry (borrow), sign and overflow bits of `cmp_a - cmp_b` are captured in a flag register at the next rising clock edge. The register holds its value until the next strobe.

While a jump-class operation is presented, the block picks the condition named by the jump kind and evaluates it against the held flags. It forms the destination from a base register value plus an immediate, or from the immediate alone when the base register ID is the reserved "no base" value 0xFF. It drives `taken` and the next instruction pointer combinationally in the same cycle. When no jump is taken, the next pointer is the sequential address supplied by the fetch side. Pushing the return address for a call and fetching instructions are handled elsewhere. There is no state machine: the only state is the flag register, which is cleared by reset and rewritten by the strobe.

Top module: `fbu_top`

## Requirements
- R1: On a rising edge with `flag_load` high, Z becomes 1 exactly when `cmp_a` equals `cmp_b`; the difference itself is not kept.
- R2: On the same edge, C becomes the borrow of the unsigned 32-bit subtraction (`cmp_a < cmp_b` unsigned), S becomes bit 31 of the difference, and O becomes signed overflow of the subtraction, so that S xor O equals `cmp_a < cmp_b` signed.
- R3: With `flag_load` low the flags keep their value whatever the compare inputs do; reset clears all four flags to 0.
- R4: The target is `imm` when `base_id` is 0xFF, and otherwise `base_val + imm` modulo 2^32.
- R5: `jmp_kind` codes: 0 always, 1 equal (Z=1), 2 not-equal (Z=0), 11 call; codes 0 and 11 are always taken and use the R4 target.
- R6: Unsigned codes: 3 below (C=1), 4 below-or-equal (C=1 or Z=1), 5 above (C=0 and Z=0), 6 above-or-equal (C=0).
- R7: Signed codes: 7 less (S!=O), 8 less-or-equal (Z=1 or S!=O), 9 greater (Z=0 and S=O), 10 greater-or-equal (S=O).
- R8: When `taken` is 1, `next_ip` equals the target; when `taken` is 0, `next_ip` equals `seq_ip`. Both respond in the same cycle as the jump inputs.
- R9: With `jmp_valid` low, or with a reserved `jmp_kind` code 12 to 15, `taken` is 0.
- R10: A jump presented in the same cycle as `flag_load` is evaluated against the flags held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_a | input | 32 | First compare operand (minuend) |
| cmp_b | input | 32 | Second compare operand (subtrahend) |
| flag_load | input | 1 | Capture the flags of `cmp_a - cmp_b` at the next edge |
| jmp_valid | input | 1 | A jump-class operation is presented this cycle |
| jmp_kind | input | 4 | Condition code selecting the jump kind |
| base_id | input | 8 | Base register ID; 0xFF means no base |
| base_val | input | 32 | Value of the base register |
| imm | input | 32 | Immediate offset or absolute target |
| seq_ip | input | 32 | Address of the following instruction |
| taken | output | 1 | The jump is taken |
| next_ip | output | 32 | Next instruction pointer |

## Verification
The assertions assume that every input is at a known value at each rising edge, and that the compare operands are stable across the edge on which `flag_load` is high. The property on the absolute target also relies on `base_id` being meaningful only while `jmp_valid` is high. The bench drives all inputs at the falling edge and gives every one a defined value from reset onward. Random operands come from a fixed seed, and every fifth pair is forced equal so that the Z-dependent conditions see both outcomes.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    localparam int XLEN      = 32;
    localparam int REG_ID_W  = 8;
    localparam int KIND_W    = 4;
    localparam logic [REG_ID_W-1:0] NO_BASE_ID = '1;

    typedef enum logic [KIND_W-1:0] {
        JK_ALWAYS      = 4'd0,
        JK_EQ          = 4'd1,
        JK_NE          = 4'd2,
        JK_BELOW       = 4'd3,
        JK_BELOW_EQ    = 4'd4,
        JK_ABOVE       = 4'd5,
        JK_ABOVE_EQ    = 4'd6,
        JK_LESS        = 4'd7,
        JK_LESS_EQ     = 4'd8,
        JK_GREATER     = 4'd9,
        JK_GREATER_EQ  = 4'd10,
        JK_CALL        = 4'd11
    } jump_kind_e;

    typedef struct packed {
        logic z;
        logic c;
        logic s;
        logic o;
    } flags_t;

endpackage

// File: rtl/fbu_flag_calc.sv
module fbu_flag_calc
    import fbu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output flags_t       flags
);
    logic [W:0] diff_ext;

    always_comb begin
        diff_ext = {1'b0, op_a} - {1'b0, op_b};
        flags.z  = (diff_ext[W-1:0] == '0);
        flags.c  = diff_ext[W];
        flags.s  = diff_ext[W-1];
        flags.o  = (op_a[W-1] ^ op_b[W-1]) & (op_a[W-1] ^ diff_ext[W-1]);
    end
endmodule

// File: rtl/fbu_cond_eval.sv
module fbu_cond_eval
    import fbu_pkg::*;
(
    input  flags_t            flags,
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    output logic              take
);
    logic sign_ne;

    always_comb begin
        sign_ne = flags.s ^ flags.o;
        take    = 1'b0;
        if (valid) begin
            case (jump_kind_e'(kind))
                JK_ALWAYS:     take = 1'b1;
                JK_CALL:       take = 1'b1;
                JK_EQ:         take = flags.z;
                JK_NE:         take = ~flags.z;
                JK_BELOW:      take = flags.c;
                JK_BELOW_EQ:   take = flags.c | flags.z;
                JK_ABOVE:      take = ~flags.c & ~flags.z;
                JK_ABOVE_EQ:   take = ~flags.c;
                JK_LESS:       take = sign_ne;
                JK_LESS_EQ:    take = flags.z | sign_ne;
                JK_GREATER:    take = ~flags.z & ~sign_ne;
                JK_GREATER_EQ: take = ~sign_ne;
                default:       take = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fbu_target_gen.sv
module fbu_target_gen
    import fbu_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int ID_W = REG_ID_W
) (
    input  logic [ID_W-1:0] base_id,
    input  logic [W-1:0]    base_val,
    input  logic [W-1:0]    imm,
    output logic [W-1:0]    target
);
    logic no_base;

    always_comb begin
        no_base = (base_id == {ID_W{1'b1}});
        target  = no_base ? imm : (base_val + imm);
    end
endmodule

// File: rtl/fbu_top.sv
module fbu_top
    import fbu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     cmp_a,
    input  logic [XLEN-1:0]     cmp_b,
    input  logic                flag_load,
    input  logic                jmp_valid,
    input  logic [KIND_W-1:0]   jmp_kind,
    input  logic [REG_ID_W-1:0] base_id,
    input  logic [XLEN-1:0]     base_val,
    input  logic [XLEN-1:0]     imm,
    input  logic [XLEN-1:0]     seq_ip,
    output logic                taken,
    output logic [XLEN-1:0]     next_ip
);
    flags_t          flags_d;
    flags_t          flags_q;
    logic            take_w;
    logic [XLEN-1:0] target_w;

    fbu_flag_calc #(.W(XLEN)) u_flags (
        .op_a  (cmp_a),
        .op_b  (cmp_b),
        .flags (flags_d)
    );

    // Flag register: cleared by reset, written only by the strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (flag_load) begin
            flags_q <= flags_d;
        end
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_load |=> $stable(flags_q)) else $error("flags moved"); // R3
    AST_ZERO_FROM_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> (flags_q.z == ($past(cmp_a) == $past(cmp_b)))) else $error("Z wrong"); // R1
    AST_BORROW_FROM_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> (flags_q.c == ($past(cmp_a) < $past(cmp_b)))) else $error("C wrong"); // R2
    AST_SIGNED_LESS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> ((flags_q.s ^ flags_q.o) == ($signed($past(cmp_a)) < $signed($past(cmp_b))))) else $error("S/O wrong"); // R2

    fbu_cond_eval u_cond (
        .flags (flags_q),
        .valid (jmp_valid),
        .kind  (jmp_kind),
        .take  (take_w)
    );

    fbu_target_gen #(.W(XLEN), .ID_W(REG_ID_W)) u_target (
        .base_id  (base_id),
        .base_val (base_val),
        .imm      (imm),
        .target   (target_w)
    );

    always_comb begin
        taken   = take_w;
        next_ip = take_w ? target_w : seq_ip;
    end

    AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !jmp_valid |-> !taken) else $error("idle take"); // R9
    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid && (jmp_kind == JK_ALWAYS || jmp_kind == JK_CALL)) |-> taken) else $error("uncond"); // R5
    AST_ABS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && base_id == NO_BASE_ID) |-> (next_ip == imm)) else $error("abs target"); // R4
    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> (next_ip == seq_ip)) else $error("fallthrough"); // R8
endmodule

// File: tb/tb_fbu_top.sv
module tb_fbu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cmp_a, cmp_b;
    logic        flag_load;
    logic        jmp_valid;
    logic [3:0]  jmp_kind;
    logic [7:0]  base_id;
    logic [31:0] base_val, imm, seq_ip;
    logic        taken;
    logic [31:0] next_ip;

    int n_vec = 0;
    int n_bad = 0;
    bit m_eq, m_ult, m_slt;

    fbu_top dut (
        .clk(clk), .rst_n(rst_n), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .flag_load(flag_load), .jmp_valid(jmp_valid), .jmp_kind(jmp_kind),
        .base_id(base_id), .base_val(base_val), .imm(imm), .seq_ip(seq_ip),
        .taken(taken), .next_ip(next_ip)
    );

    always #5 clk = ~clk;

    function automatic bit exp_take(int k, bit eq, bit ult, bit slt);
        case (k)
            0, 11: return 1'b1;
            1:  return eq;
            2:  return !eq;
            3:  return ult;
            4:  return ult || eq;
            5:  return !ult && !eq;
            6:  return !ult;
            7:  return slt;
            8:  return slt || eq;
            9:  return !slt && !eq;
            10: return !slt;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string kind_req(int k);
        if (k == 0 || k == 1 || k == 2 || k == 11) return "R5";
        if (k >= 3 && k <= 6) return "R6";
        if (k >= 7 && k <= 10) return "R7";
        return "R9";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cmp(logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        cmp_a = a; cmp_b = b; flag_load = 1'b1; jmp_valid = 1'b0;
        @(negedge clk);
        flag_load = 1'b0;
        m_eq  = (a == b);
        m_ult = (a < b);
        m_slt = ($signed(a) < $signed(b));
    endtask

    task automatic sweep(string tag);
        for (int k = 0; k < 16; k++) begin
            logic [31:0] tgt;
            bit et;
            @(negedge clk);
            jmp_valid = 1'b1;
            jmp_kind  = 4'(k);
            base_id   = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 255);
            base_val  = $urandom;
            imm       = $urandom;
            seq_ip    = $urandom;
            #1;
            et  = exp_take(k, m_eq, m_ult, m_slt);
            tgt = (base_id == 8'hFF) ? imm : base_val + imm;
            check($sformatf("%s %s kind=%0d taken", tag, kind_req(k), k), 32'(taken), 32'(et));
            check($sformatf("%s %s next_ip", tag, (base_id == 8'hFF) ? "R4" : "R8"),
                  next_ip, et ? tgt : seq_ip);
        end
        @(negedge clk);
        jmp_valid = 1'b0;
        jmp_kind  = 4'd0;
        #1;
        check("R9 idle taken", 32'(taken), 32'd0);
        check("R8 idle next_ip", next_ip, seq_ip);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] da [8];
        logic [31:0] db [8];
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cmp_a = '0; cmp_b = '0; flag_load = 1'b0;
        jmp_valid = 1'b0; jmp_kind = '0; base_id = '0; base_val = '0;
        imm = '0; seq_ip = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset clears flags, seen as Z=0 C=0 S=O
        m_eq = 0; m_ult = 0; m_slt = 0;
        sweep("R3 reset");

        // Directed corner pairs for R1/R2
        da = '{32'h0, 32'h1, 32'h2, 32'h8000_0000, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 32'h0};
        db = '{32'h0, 32'h2, 32'h1, 32'h1, 32'hffff_ffff, 32'h7fff_ffff, 32'hffff_ffff, 32'hffff_ffff};
        for (int i = 0; i < 8; i++) begin
            load_cmp(da[i], db[i]);
            sweep("R1 R2 directed");
        end

        // R3: hold with compare inputs changing and strobe low
        load_cmp(32'h5, 32'h9);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cmp_a = $urandom; cmp_b = cmp_a;
        end
        sweep("R3 hold");

        // R4: wrap of base plus offset
        @(negedge clk);
        jmp_valid = 1'b1; jmp_kind = 4'd0; base_id = 8'h03;
        base_val = 32'hffff_fff0; imm = 32'h0000_0020; seq_ip = 32'h100;
        #1;
        check("R4 wrap", next_ip, 32'h0000_0010);
        base_id = 8'hFF;
        #1;
        check("R4 absolute", next_ip, 32'h0000_0020);

        // R10: jump in the same cycle as a flag load sees old flags
        load_cmp(32'h7, 32'h7);
        @(negedge clk);
        cmp_a = 32'h1; cmp_b = 32'h2; flag_load = 1'b1;
        jmp_valid = 1'b1; jmp_kind = 4'd1; base_id = 8'hFF; imm = 32'h40; seq_ip = 32'h44;
        #1;
        check("R10 old flags taken", 32'(taken), 32'd1);
        @(negedge clk);
        flag_load = 1'b0;
        #1;
        check("R10 new flags taken", 32'(taken), 32'd0);
        m_eq = 0; m_ult = 1; m_slt = 1;

        // Constrained random operands
        for (int i = 0; i < 200; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = (i % 5 == 0) ? a : ((i % 7 == 0) ? (a ^ 32'h8000_0000) : $urandom);
            load_cmp(a, b);
            sweep("R1 R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule